// File: doc/BRIEF.md
# Threshold-Gated Output Tracker

The block watches a scaled sample and forwards it to a held output only while a two-state controller sits in its active state. Each cycle, the two signed input operands are added and the sum is multiplied by an integer gain constant. That product is the monitored value, and it is compared against a fixed threshold of 100.

The controller has two states, idle and tracking. From idle it moves to tracking when the monitored value reaches the threshold. From tracking it drops back to idle when the value falls below the threshold. On any clock edge where the controller stays in tracking, the held output register takes the monitored value. On any edge where the state changes, the held output is left as it was. On every other edge the held output also keeps its value.

The logic is split into two concurrent parts. A combinational part copies the current state into a local shadow, evaluates the transition on that shadow, raises a load strobe and yields a speculative next state. A clocked part copies the next state into the current state on the clock edge, and an asynchronous reset can also set it. Arithmetic, the threshold compare and the held register form a datapath. The controller drives that datapath through a small struct of strobes.

Top module: `gated_tracker`

## Requirements
- R1: While the active-low asynchronous reset `rstN` is low, the controller is in idle (`tracking` = 0) and `heldOut` = 0. Both take effect without waiting for a clock edge.
- R2: The monitored value is the signed 32-bit product (`opA` + `opB`) * GAIN, where `opA` and `opB` are signed 16-bit inputs. The threshold test is monitored >= 100, taken as a signed compare.
- R3: In idle with monitored >= 100, the next edge moves the controller to tracking, and `heldOut` is unchanged on that edge.
- R4: In idle with monitored < 100, the controller stays in idle and `heldOut` is unchanged.
- R5: In tracking with monitored < 100, the next edge moves the controller to idle, and `heldOut` is unchanged on that edge.
- R6: In tracking with monitored >= 100, the controller stays in tracking and `heldOut` takes the monitored value on that edge.
- R7: On no edge does the state change and `heldOut` get written together.
- R8: `heldOut` keeps its value on every edge where the controller does not stay in tracking.
- R9: `tracking` is 1 exactly when the controller is in tracking. The state register holds only the idle code (0) or the tracking code (1). Any other value is sent to tracking on the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First signed operand |
| opB | input | 16 | Second signed operand |
| heldOut | output | 32 | Held copy of the monitored value, signed |
| tracking | output | 1 | High while the controller is in the tracking state |

## Verification
The bench builds the block with GAIN = 4. With that gain, an operand sum of 25 lands exactly on the threshold of 100, and a sum of 24 gives 96, just below it. This puts the boundary on both sides within reach of small stimulus. Large operand sums near the 16-bit limits and negative sums exercise the signed widening into the 32-bit product. A mid-run reset asserted between clock edges checks that the asynchronous clear of both the state and `heldOut` takes effect at once.

// File: rtl/gated_tracker_pkg.sv
package gated_tracker_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1
  } trackState_e;

  typedef struct packed {
    logic loadOut;
  } ctrlStrobe_t;

endpackage

// File: rtl/gated_tracker_dp.sv
module gated_tracker_dp
  import gated_tracker_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int PROD_W = 32,
  parameter int GAIN   = 2,
  parameter int THRESH = 100
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [IN_W-1:0]   opA,
  input  logic signed [IN_W-1:0]   opB,
  input  ctrlStrobe_t              strobe,
  output logic                     atOrAbove,
  output logic signed [PROD_W-1:0] heldOut
);

  localparam int SUM_W = IN_W + 1;
  localparam logic signed [PROD_W-1:0] GAIN_S   = PROD_W'(GAIN);
  localparam logic signed [PROD_W-1:0] THRESH_S = PROD_W'(THRESH);

  logic signed [SUM_W-1:0]  opSum;
  logic signed [PROD_W-1:0] sumWide;
  logic signed [PROD_W-1:0] monitored;

  always_comb begin
    opSum     = SUM_W'(opA) + SUM_W'(opB);
    sumWide   = PROD_W'(opSum);
    monitored = sumWide * GAIN_S;
    atOrAbove = (monitored >= THRESH_S);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heldOut <= '0;
    else if (strobe.loadOut) heldOut <= monitored;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOut |=> $stable(heldOut)); // R8

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |=> heldOut == $past(monitored)); // R6

  AST_LOAD_ONLY_AT_THRESH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |-> atOrAbove); // R6

endmodule

// File: rtl/gated_tracker_ctrl.sv
module gated_tracker_ctrl
  import gated_tracker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        atOrAbove,
  output ctrlStrobe_t strobe,
  output logic        tracking
);

  trackState_e curState;
  trackState_e nextState;

  always_comb begin
    trackState_e shadow;
    shadow         = curState;
    strobe.loadOut = 1'b0;
    case (shadow)
      ST_IDLE: begin
        if (atOrAbove) shadow = ST_TRACK;
      end
      ST_TRACK: begin
        if (!atOrAbove) shadow = ST_IDLE;
        else strobe.loadOut = 1'b1;
      end
      default: shadow = ST_TRACK;
    endcase
    nextState = shadow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else curState <= nextState;
  end

  assign tracking = (curState == ST_TRACK);

  AST_ENTER_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && atOrAbove) |=> curState == ST_TRACK); // R3

  AST_STAY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && !atOrAbove) |=> curState == ST_IDLE); // R4

  AST_LEAVE_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_TRACK && !atOrAbove) |=> curState == ST_IDLE); // R5

  AST_WRITE_XOR_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |=> $stable(curState)); // R7

  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rstN)
    curState == ST_IDLE || curState == ST_TRACK); // R9

endmodule

// File: rtl/gated_tracker.sv
module gated_tracker
  import gated_tracker_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int PROD_W = 32,
  parameter int GAIN   = 2,
  parameter int THRESH = 100
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [IN_W-1:0]   opA,
  input  logic signed [IN_W-1:0]   opB,
  output logic signed [PROD_W-1:0] heldOut,
  output logic                     tracking
);

  ctrlStrobe_t strobe;
  logic        atOrAbove;

  gated_tracker_dp #(
    .IN_W(IN_W), .PROD_W(PROD_W), .GAIN(GAIN), .THRESH(THRESH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .strobe(strobe), .atOrAbove(atOrAbove), .heldOut(heldOut)
  );

  gated_tracker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .atOrAbove(atOrAbove),
    .strobe(strobe), .tracking(tracking)
  );

endmodule

// File: tb/gated_tracker_tb.sv
module gated_tracker_tb;

  localparam int GAIN = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic signed [15:0] opA = '0;
  logic signed [15:0] opB = '0;
  logic signed [31:0] heldOut;
  logic               tracking;

  int compared = 0;
  int mismatched = 0;
  bit modelTrack = 1'b0;
  longint modelOut = 0;
  string lastTag = "R4";

  always #2 clk = ~clk;

  gated_tracker #(.GAIN(GAIN)) u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .heldOut(heldOut), .tracking(tracking)
  );

  task automatic compare(input string tag);
    compared++;
    if (longint'(heldOut) != modelOut) begin
      mismatched++;
      $display("FAIL %s heldOut actual=%0d expected=%0d", tag, heldOut, modelOut);
    end
    compared++;
    if (tracking != modelTrack) begin
      mismatched++;
      $display("FAIL R9 (%s) tracking actual=%0b expected=%0b", tag, tracking, modelTrack);
    end
  endtask

  // R2: monitored = (a+b)*GAIN; model state update per edge
  task automatic step(input int a, input int b);
    longint mon;
    opA = 16'(a);
    opB = 16'(b);
    @(posedge clk);
    mon = longint'(a + b) * GAIN;
    if (!modelTrack) begin
      if (mon >= 100) begin modelTrack = 1'b1; lastTag = "R3"; end
      else lastTag = "R4";
    end else begin
      if (mon < 100) begin modelTrack = 1'b0; lastTag = "R5"; end
      else begin modelOut = mon; lastTag = "R6"; end
    end
    @(negedge clk);
    compare(lastTag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    #1;
    compare("R1");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1");
    step(10, 5);      // R4 idle, 60
    step(-300, 100);  // R4 negative
    step(12, 12);     // R4 96, just below
    step(20, 5);      // R3 exactly 100, output stays 0
    step(20, 5);      // R6 load 100
    step(30, 7);      // R6 load 148
    step(30000, 30000); // R6 large sum
    step(-30000, 100);  // R5 leave, output frozen (R7)
    step(40, 40);     // R3 re-enter, no write (R7)
    step(24, 0);      // R5 96 leave
    step(-5, 3);      // R8 hold in idle
    step(24, 1);      // R3
    step(25, 1);      // R6 104
    // R1 asynchronous reset between edges
    @(negedge clk);
    #1 rstN = 1'b0;
    #0.5;
    modelTrack = 1'b0; modelOut = 0;
    compare("R1");
    @(negedge clk);
    rstN = 1'b1;
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      int s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = int'(lfsr[5:0]) - 8;
      step(s, int'(lfsr[9:8]));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule